// File: doc/BRIEF.md
# Absolute Gray Track Merger

This block joins the coarse tracks of an optical absolute position reader with two fine quadrature signals and a set of interpolated fine bits, and produces one 16-bit Gray-coded position word. The coarse tracks come from comparators and switch at slightly wrong positions. The quadrature pair, made from conditioned analog signals, switches at exact positions. When correction is on, the block re-times the coarse tracks against the quadrature pair, so the merged word changes by one bit per position step, even across the coarse track edges.

All track and control inputs are asynchronous to the clock and pass through a two-flop synchronizer. A position sample is requested on a valid/ready stream input. Each accepted request loads the output register once, and the result leaves on a valid/ready stream output. A request is accepted only when the output register is empty, or is being emptied in the same cycle. A consumer that holds `pos_ready` low therefore stalls the requester. The word it holds stays frozen until it is taken. Correction covers the upper 12 bits only. The interpolated bits are appended below them as they arrive. A direction control inverts the top bit, which reverses the counting sense of the Gray word.

Top module: `gray_track_merger`

## Requirements
- R1: Every track and control input passes through two flops. An input change made between rising edges k and k+1 is captured by a request accepted on edge k+3, and is not yet captured by a request accepted on edge k+2.
- R2: With `fix_en`=1, the block converts the coarse Gray bits (`trk_coarse[0]` is the finest coarse track) to binary. It decodes the quadrant as {`quad_b`, `quad_b`^`quad_a`}. If the binary low bit differs from the quadrant high bit, the block adds one to the coarse value when the quadrant low bit is 0, and subtracts one when it is 1. The adjustment wraps modulo 2^11. The result, with the quadrant low bit appended below it, is converted back to Gray and forms `pos_word[15:4]`. This gives the exact position for coarse skew of up to 15 fine steps either way, including across the wrap point.
- R3: With `fix_en`=0, `pos_word[15:4]` equals {`trk_coarse`, `quad_a`} unchanged, and `quad_b` has no effect on the word.
- R4: `pos_word[3:0]` always equals `trk_interp[3:0]` as captured, in both correction modes.
- R5: The word layout is: `trk_coarse[i]` at bit 5+i, `quad_a` at bit 4, and the interpolated bits at bits 3..0.
- R6: With `dir_inv`=1, only bit 15 of the word is inverted.
- R7: `smp_ready` is high exactly when `pos_valid` is low or `pos_ready` is high. An accepted request loads `pos_word` and sets `pos_valid` on the same edge.
- R8: While `pos_valid`=1 and `pos_ready`=0, `pos_word` and `pos_valid` hold, whatever the inputs do.
- R9: When the word is taken (`pos_valid` and `pos_ready`) and no request is accepted, `pos_valid` falls on that edge.
- R10: While reset is asserted, `pos_valid`=0, `pos_word`=0 and `smp_ready`=1.
- R11: With correction on, sweeping all 65536 positions in either direction, with per-step coarse skew within ±15, gives a word that changes in exactly one bit per step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trk_coarse | input | 11 | Coarse Gray track bits, bit 0 finest |
| quad_a | input | 1 | Digitized fine signal, in-phase |
| quad_b | input | 1 | Digitized fine signal, 90 degrees shifted |
| trk_interp | input | 4 | Interpolated fine Gray bits, bit 3 coarsest |
| fix_en | input | 1 | 1 = re-time coarse tracks to quadrature |
| dir_inv | input | 1 | 1 = invert top bit of the word |
| smp_valid | input | 1 | Sample request |
| smp_ready | output | 1 | Sample request accepted when high with smp_valid |
| pos_valid | output | 1 | Output word present |
| pos_ready | input | 1 | Consumer takes the word |
| pos_word | output | 16 | Merged Gray position word |

## Verification
The hardest case to reach is a coarse track switching at a different position from the quadrature edge it belongs to. The worst versions are skew at the very limit of the tolerated window, and skew across the all-ones to all-zeros wrap. The stimulus models skew by deriving the coarse tracks from a shifted copy of the true position. The shift changes from step to step over -15..+15 while a full sweep runs up and down. Directed points put the shift at exactly +15 and -15 next to a coarse edge and at the wrap. Stalling the consumer while the inputs keep moving tests the hold rule.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int unsigned COARSE_W_DEF = 11;
  localparam int unsigned FINE_W_DEF   = 4;

  typedef enum logic [1:0] {
    STEP_KEEP = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Quadrant of the fine cycle as a 2-bit binary count.
  function automatic logic [1:0] quad_pos(input logic qb, input logic qa);
    return {qb, qb ^ qa};
  endfunction
endpackage

// File: rtl/gtm_sync.sv
module gtm_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/gtm_gray2bin.sv
module gtm_gray2bin #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);
  // Each binary bit is the parity of all Gray bits at or above it.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end
endmodule

// File: rtl/gtm_quad_align.sv
module gtm_quad_align
  import gtm_pkg::*;
#(
  parameter int unsigned CW = 11
) (
  input  logic [CW-1:0] coarse_g,
  input  logic [CW-1:0] coarse_b,
  input  logic          qa,
  input  logic          qb,
  input  logic          en,
  output logic [CW-1:0] fix_b,
  output logic [CW:0]   hi_g
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [1:0]  qpos;
  step_e       step;
  logic [CW:0] hi_b;
  logic [CW:0] hi_g_fix;

  assign qpos = quad_pos(qb, qa);

  // Coarse low bit must agree with the quadrant half; if not, move it
  // toward the quadrant: early quadrant half -> coarse lags, late -> leads.
  always_comb begin
    step = STEP_KEEP;
    if (coarse_b[0] != qpos[1]) begin
      step = qpos[0] ? STEP_DOWN : STEP_UP;
    end
  end

  always_comb begin
    case (step)
      STEP_UP:   fix_b = coarse_b + ONE;
      STEP_DOWN: fix_b = coarse_b - ONE;
      default:   fix_b = coarse_b;
    endcase
  end

  assign hi_b     = {fix_b, qpos[0]};
  assign hi_g_fix = hi_b ^ (hi_b >> 1);
  assign hi_g     = en ? hi_g_fix : {coarse_g, qa};
endmodule

// File: rtl/gtm_out_stage.sv
module gtm_out_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] word_in,
  input  logic         inv,
  output logic         pos_valid,
  input  logic         pos_ready,
  output logic [W-1:0] pos_word
);
  localparam logic [W-1:0] TOP_MASK = {1'b1, {(W-1){1'b0}}};

  logic take;

  assign smp_ready = !pos_valid || pos_ready;
  assign take      = smp_valid && smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_valid <= 1'b0;
      pos_word  <= '0;
    end else if (take) begin
      pos_valid <= 1'b1;
      pos_word  <= word_in ^ (inv ? TOP_MASK : '0);
    end else if (pos_ready) begin
      pos_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gray_track_merger.sv
module gray_track_merger #(
  parameter  int unsigned COARSE_W = gtm_pkg::COARSE_W_DEF,
  parameter  int unsigned FINE_W   = gtm_pkg::FINE_W_DEF,
  localparam int unsigned WORD_W   = COARSE_W + 1 + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COARSE_W-1:0] trk_coarse,
  input  logic                quad_a,
  input  logic                quad_b,
  input  logic [FINE_W-1:0]   trk_interp,
  input  logic                fix_en,
  input  logic                dir_inv,
  input  logic                smp_valid,
  output logic                smp_ready,
  output logic                pos_valid,
  input  logic                pos_ready,
  output logic [WORD_W-1:0]   pos_word
);
  localparam int unsigned SYNC_W = COARSE_W + FINE_W + 4;

  logic [SYNC_W-1:0]   raw_in;
  logic [SYNC_W-1:0]   sync_out;
  logic [COARSE_W-1:0] coarse_s;
  logic [FINE_W-1:0]   interp_s;
  logic                qa_s, qb_s, en_s, inv_s;
  logic [COARSE_W-1:0] coarse_bin;
  logic [COARSE_W-1:0] fix_bin;
  logic [COARSE_W:0]   hi_g;
  logic [WORD_W-1:0]   merged;

  assign raw_in = {inv_pin(dir_inv), fix_en, trk_interp, quad_b, quad_a, trk_coarse};
  function automatic logic inv_pin(input logic v);
    return v;
  endfunction

  gtm_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign {inv_s, en_s, interp_s, qb_s, qa_s, coarse_s} = sync_out;

  gtm_gray2bin #(.W(COARSE_W)) u_g2b (
    .g (coarse_s),
    .b (coarse_bin)
  );

  gtm_quad_align #(.CW(COARSE_W)) u_align (
    .coarse_g (coarse_s),
    .coarse_b (coarse_bin),
    .qa       (qa_s),
    .qb       (qb_s),
    .en       (en_s),
    .fix_b    (fix_bin),
    .hi_g     (hi_g)
  );

  assign merged = {hi_g, interp_s};

  gtm_out_stage #(.W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .word_in   (merged),
    .inv       (inv_s),
    .pos_valid (pos_valid),
    .pos_ready (pos_ready),
    .pos_word  (pos_word)
  );
endmodule

// File: rtl/gtm_checks.sv
module gtm_checks #(
  parameter int unsigned CW = 11,
  parameter int unsigned FW = 4,
  parameter int unsigned W  = CW + 1 + FW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          pos_valid,
  input logic          pos_ready,
  input logic [W-1:0]  pos_word,
  input logic          en_s,
  input logic          inv_s,
  input logic          qa_s,
  input logic          qb_s,
  input logic [CW-1:0] coarse_s,
  input logic [FW-1:0] interp_s,
  input logic [CW-1:0] fix_bin,
  input logic [CW:0]   hi_g
);
  // R2: corrected coarse low bit agrees with the quadrant half
  p_quad_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |-> (fix_bin[0] == qb_s));

  // R2: corrected Gray lowest bit of the upper part equals the in-phase signal
  p_quad_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |-> (hi_g[0] == qa_s));

  // R3: bypass passes coarse and in-phase bits untouched
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |-> (hi_g == {coarse_s, qa_s}));

  // R4: interpolated bits land in the word uncorrected
  p_fine_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (pos_word[FW-1:0] == $past(interp_s)));

  // R6: top bit follows merged top bit xor direction control
  p_top_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (pos_word[W-1] == $past(hi_g[CW] ^ inv_s)));

  // R7: accepted request leaves a valid word
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> pos_valid);

  // R7: empty output always accepts
  p_empty_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_valid |-> smp_ready);

  // R8: stalled word holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && !pos_ready) |=> (pos_valid && $stable(pos_word)));

  // R9: taken word with no new request empties the output
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && pos_ready && !smp_valid) |=> !pos_valid);
endmodule

bind gray_track_merger gtm_checks #(.CW(COARSE_W), .FW(FINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .pos_valid (pos_valid),
  .pos_ready (pos_ready),
  .pos_word  (pos_word),
  .en_s      (en_s),
  .inv_s     (inv_s),
  .qa_s      (qa_s),
  .qb_s      (qb_s),
  .coarse_s  (coarse_s),
  .interp_s  (interp_s),
  .fix_bin   (fix_bin),
  .hi_g      (hi_g)
);

// File: tb/tb_gray_track_merger.sv
`timescale 1ns/1ps
module tb_gray_track_merger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] trk_coarse = '0;
  logic        quad_a = 1'b0;
  logic        quad_b = 1'b0;
  logic [3:0]  trk_interp = '0;
  logic        fix_en = 1'b0;
  logic        dir_inv = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic        pos_valid;
  logic        pos_ready = 1'b1;
  logic [15:0] pos_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gray_track_merger dut (
    .clk(clk), .rst_n(rst_n), .trk_coarse(trk_coarse), .quad_a(quad_a),
    .quad_b(quad_b), .trk_interp(trk_interp), .fix_en(fix_en),
    .dir_inv(dir_inv), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .pos_valid(pos_valid), .pos_ready(pos_ready), .pos_word(pos_word)
  );

  function automatic logic [15:0] g16(input logic [15:0] p);
    return p ^ (p >> 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive the tracks for true position p, coarse tracks read at p+skew.
  task automatic drive_pos(input logic [15:0] p, input int skew);
    logic [15:0] ps;
    logic [15:0] g;
    logic [15:0] gs;
    ps = p + 16'(skew);
    g  = g16(p);
    gs = g16(ps);
    trk_coarse = gs[15:5];
    quad_a     = g[4];
    quad_b     = p[5];
    trk_interp = g[3:0];
  endtask

  task automatic settle();
    smp_valid = 1'b1;
    pos_ready = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic apply_raw(input logic [10:0] c, input logic a, input logic b,
                           input logic [3:0] f, input logic en, input logic inv);
    trk_coarse = c; quad_a = a; quad_b = b; trk_interp = f;
    fix_en = en; dir_inv = inv;
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    smp_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(pos_valid == 1'b0, "R10 valid in reset", 16'(pos_valid), 16'h0);
    check(pos_word == 16'h0, "R10 word in reset", pos_word, 16'h0);
    check(smp_ready == 1'b1, "R10 ready in reset", 16'(smp_ready), 16'h1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_latency();
    apply_raw(11'h155, 1'b0, 1'b0, 4'h3, 1'b0, 1'b0);
    smp_valid = 1'b0;
    @(negedge clk);
    trk_coarse = 11'h2AA; quad_a = 1'b1; trk_interp = 4'hC;
    @(negedge clk);
    smp_valid = 1'b1;
    @(negedge clk);
    check(pos_word == 16'h2AA3, "R1 not yet captured", pos_word, 16'h2AA3);
    @(negedge clk);
    check(pos_word == 16'h555C, "R1 captured", pos_word, 16'h555C);
  endtask

  task automatic t_bypass_layout();
    apply_raw(11'h001, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0);
    check(pos_word == 16'h0020, "R5 coarse bit0 at bit5", pos_word, 16'h0020);
    apply_raw(11'h400, 1'b1, 1'b0, 4'h9, 1'b0, 1'b0);
    check(pos_word == 16'h8019, "R5 layout top and fine", pos_word, 16'h8019);
    apply_raw(11'h400, 1'b1, 1'b1, 4'h9, 1'b0, 1'b0);
    check(pos_word == 16'h8019, "R3 quad_b ignored in bypass", pos_word, 16'h8019);
    apply_raw(11'h0F0, 1'b0, 1'b1, 4'h6, 1'b0, 1'b0);
    check(pos_word == 16'h1E06, "R3 bypass unchanged coarse", pos_word, 16'h1E06);
    apply_raw(11'h400, 1'b1, 1'b0, 4'h9, 1'b0, 1'b1);
    check(pos_word == 16'h0019, "R6 only top bit inverted", pos_word, 16'h0019);
  endtask

  task automatic t_correct_points();
    logic [15:0] e;
    fix_en = 1'b1; dir_inv = 1'b0;
    // coarse leads by 15 just below an edge
    drive_pos(16'h0031, 15); settle();
    e = g16(16'h0031);
    check(pos_word == e, "R2 skew +15", pos_word, e);
    // coarse lags by 15 just after an edge
    drive_pos(16'h0020, -15); settle();
    e = g16(16'h0020);
    check(pos_word == e, "R2 skew -15", pos_word, e);
    // coarse wraps to zero while true position is all ones
    drive_pos(16'hFFFF, 15); settle();
    e = g16(16'hFFFF);
    check(pos_word == e, "R2 wrap down", pos_word, e);
    drive_pos(16'h0000, -15); settle();
    e = g16(16'h0000);
    check(pos_word == e, "R2 wrap up", pos_word, e);
    // interpolated bits not corrected
    drive_pos(16'h1234, 0); trk_interp = 4'hA; settle();
    e = {g16(16'h1234)[15:4], 4'hA};
    check(pos_word == e, "R4 fine bits as given", pos_word, e);
  endtask

  task automatic t_backpressure();
    apply_raw(11'h123, 1'b1, 1'b0, 4'h5, 1'b0, 1'b0);
    pos_ready = 1'b0;
    @(negedge clk);
    check(smp_ready == 1'b0, "R7 ready low when full and stalled", 16'(smp_ready), 16'h0);
    trk_coarse = 11'h456; quad_a = 1'b0; trk_interp = 4'hE;
    repeat (4) @(negedge clk);
    check(pos_word == 16'h2475, "R8 word held under stall", pos_word, 16'h2475);
    check(pos_valid == 1'b1, "R8 valid held under stall", 16'(pos_valid), 16'h1);
    smp_valid = 1'b0; pos_ready = 1'b1;
    @(negedge clk);
    check(pos_valid == 1'b0, "R9 valid drops after take", 16'(pos_valid), 16'h0);
    check(smp_ready == 1'b1, "R7 ready when empty", 16'(smp_ready), 16'h1);
    smp_valid = 1'b1;
    @(negedge clk);
    check(pos_word == 16'h8ACE, "R7 load new word", pos_word, 16'h8ACE);
    check(pos_valid == 1'b1, "R7 valid after load", 16'(pos_valid), 16'h1);
  endtask

  // R11 sweep with moving coarse skew
  task automatic t_sweep(input bit down, input bit inv, input logic [15:0] start,
                         input string tag);
    logic [15:0] expq [4];
    logic [15:0] prev;
    logic [15:0] p;
    logic [15:0] last_act;
    logic [15:0] last_exp;
    int errs;
    int jumps;
    errs = 0; jumps = 0; prev = '0; last_act = '0; last_exp = '0;
    fix_en = 1'b1; dir_inv = inv;
    drive_pos(start, 0);
    settle();
    for (int i = 0; i < 65536 + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        if (pos_word !== expq[(i - 3) % 4]) begin
          errs++;
          last_act = pos_word;
          last_exp = expq[(i - 3) % 4];
        end
        if (i >= 4 && $countones(pos_word ^ prev) != 1) jumps++;
        prev = pos_word;
      end
      if (i < 65536) begin
        p = down ? start - 16'(i) : start + 16'(i);
        drive_pos(p, ((i * 7) % 31) - 15);
        expq[i % 4] = g16(p) ^ {inv, 15'h0};
      end
    end
    check(errs == 0, {"R11 R2 sweep value ", tag}, last_act, last_exp);
    check(jumps == 0, {"R11 one bit per step ", tag}, 16'(jumps), 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_bypass_layout();
    t_correct_points();
    t_backpressure();
    t_sweep(1'b0, 1'b0, 16'h9C40, "up");
    t_sweep(1'b1, 1'b1, 16'h0000, "down inverted");
    finish_run();
  end
endmodule